// File: doc/BRIEF.md
# Per-Instruction Stride Learning Table

This block watches a stream of memory requests and learns, for each load or store instruction, the distance between consecutive addresses it touches. Each request carries the instruction's program counter, the accessed address, a secure-world flag and a requester context number. Every context owns a private set-associative table. The program counter is folded into a set index. A hit in that set updates the stored stride and a saturating confidence count. A miss claims a way that a free-running pseudo-random sequence picks.

When a hit leaves the confidence at or above a threshold, the block raises a registered trigger one cycle later. The trigger carries the request address and the stride just observed, and a downstream address generator uses it as a seed. Requests without a program counter and instruction fetches pass through without effect. The block accepts one request per clock and never stalls.

Top module: `stride_trainer`

## Requirements
- R1: A request with `reqHasPc`=0 or `reqIsFetch`=1 leaves every table entry unchanged and yields `trigValid`=0 on the next cycle.
- R2: The set index is (h1 XOR (h1 >> log2(SETS))) truncated to log2(SETS) bits, where h1 = `reqPc` >> 1. SETS is a power of two.
- R3: A lookup hits only on a valid way of the indexed set, in the table of context `reqCtx`, whose stored PC and secure flag both equal the request's. Tables of different contexts never interact.
- R4: On a hit the observed stride is `reqAddr` minus the stored last address, modulo 2^ADDR_W. If it equals the stored stride, confidence rises by one but never above MAX_CONF.
- R5: On a hit whose observed stride differs from the stored stride, confidence falls by one only when it is above MIN_CONF. If the resulting confidence is below THR_CONF, the stored stride becomes the observed stride.
- R6: Every hit stores `reqAddr` as the entry's last address.
- R7: One cycle after an accepted hit whose updated confidence is at least THR_CONF, `trigValid`=1, `trigBase`=`reqAddr`, `trigStride`=observed stride and `trigSecure`=`reqSecure`. In every other case `trigValid`=0 on the next cycle.
- R8: A miss writes way (LFSR mod WAYS) of the indexed set with the PC, the secure flag, last address = `reqAddr`, stride 0 and confidence START_CONF, and marks it valid. A miss never raises a trigger.
- R9: The way picker is an 8-bit LFSR. It resets to 8'h01 and on every clock after reset becomes {l[6:0], l[7]^l[5]^l[4]^l[3]}. A miss uses its value from before the edge.
- R10: After reset every way of every context is invalid and `trigValid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request present this cycle |
| reqPc | input | PC_W | Program counter of the requesting instruction |
| reqAddr | input | ADDR_W | Accessed address |
| reqSecure | input | 1 | Secure-world flag |
| reqCtx | input | CTX_W | Requester context number |
| reqIsFetch | input | 1 | Request is an instruction fetch |
| reqHasPc | input | 1 | Request carries a program counter |
| trigValid | output | 1 | Trigger present |
| trigBase | output | ADDR_W | Address the trigger starts from |
| trigStride | output | ADDR_W | Observed stride, two's complement |
| trigSecure | output | 1 | Secure flag of the triggering request |

## Verification
The bench builds the block with its defaults: 16 sets, 4 ways, 2 contexts and confidence limits 7/4/0/4. A handful of steady-stride accesses therefore drives an entry to saturation, and a short run of mismatches pushes it down to the floor. Program counters that are multiples of 1024 all fold to set 0, so five or more of them force LFSR-chosen evictions in a 4-way set. Because the LFSR is fully specified, the reference model can predict exactly which entry survives.

// File: rtl/stride_pkg.sv
`timescale 1ns/1ps
package stride_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic wrHit;    // update an existing way
    logic wrFill;   // allocate a way
    logic retrain;  // replace stored stride by observed stride
    logic fire;     // load the trigger register
  } strobe_t;
endpackage

// File: rtl/stride_dp.sv
`timescale 1ns/1ps
module stride_dp
  import stride_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int ADDR_W = 32,
  parameter int SETS   = 16,
  parameter int WAYS   = 4,
  parameter int CTXS   = 2,
  parameter int CONF_W = 3,
  parameter int CTX_W  = 1,
  parameter int WAY_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PC_W-1:0]   reqPc,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqSecure,
  input  logic [CTX_W-1:0]  reqCtx,
  input  strobe_t           strb,
  input  logic [WAY_W-1:0]  wrWay,
  input  logic [CONF_W-1:0] confNext,
  output logic              hit,
  output logic [WAY_W-1:0]  hitWay,
  output logic [CONF_W-1:0] curConf,
  output logic              strideEq,
  output logic [WAYS-1:0]   matchVec,
  output logic              trigValid,
  output logic [ADDR_W-1:0] trigBase,
  output logic [ADDR_W-1:0] trigStride,
  output logic              trigSecure
);
  localparam int SET_W = $clog2(SETS);

  function automatic logic [SET_W-1:0] setHash(input logic [PC_W-1:0] pc);
    logic [PC_W-1:0] h1, mix;
    h1  = pc >> 1;
    mix = h1 ^ (h1 >> SET_W);
    return mix[SET_W-1:0];
  endfunction

  logic              entValid  [CTXS][SETS][WAYS];
  logic [PC_W-1:0]   entPc     [CTXS][SETS][WAYS];
  logic              entSec    [CTXS][SETS][WAYS];
  logic [ADDR_W-1:0] entLast   [CTXS][SETS][WAYS];
  logic [ADDR_W-1:0] entStride [CTXS][SETS][WAYS];
  logic [CONF_W-1:0] entConf   [CTXS][SETS][WAYS];

  logic [SET_W-1:0]  setIdx;
  logic [ADDR_W-1:0] obsStride;

  assign setIdx = setHash(reqPc);

  // per-way tag compare
  genvar gw;
  generate
    for (gw = 0; gw < WAYS; gw++) begin : g_cmp
      assign matchVec[gw] = entValid[reqCtx][setIdx][gw]
                         && (entPc[reqCtx][setIdx][gw] == reqPc)
                         && (entSec[reqCtx][setIdx][gw] == reqSecure);
    end
  endgenerate

  always_comb begin
    hitWay = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (matchVec[w]) hitWay = WAY_W'(w);
  end

  assign hit       = |matchVec;
  assign curConf   = entConf[reqCtx][setIdx][hitWay];
  assign obsStride = reqAddr - entLast[reqCtx][setIdx][hitWay];
  assign strideEq  = (obsStride == entStride[reqCtx][setIdx][hitWay]);

  // valid bits: the only table state cleared by reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int c = 0; c < CTXS; c++)
        for (int s = 0; s < SETS; s++)
          for (int w = 0; w < WAYS; w++)
            entValid[c][s][w] <= 1'b0;
    end else if (strb.wrFill) begin
      entValid[reqCtx][setIdx][wrWay] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.wrFill) begin
      entPc[reqCtx][setIdx][wrWay]     <= reqPc;
      entSec[reqCtx][setIdx][wrWay]    <= reqSecure;
      entLast[reqCtx][setIdx][wrWay]   <= reqAddr;
      entStride[reqCtx][setIdx][wrWay] <= '0;
      entConf[reqCtx][setIdx][wrWay]   <= confNext;
    end else if (strb.wrHit) begin
      entLast[reqCtx][setIdx][wrWay] <= reqAddr;
      entConf[reqCtx][setIdx][wrWay] <= confNext;
      if (strb.retrain) entStride[reqCtx][setIdx][wrWay] <= obsStride;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trigValid  <= 1'b0;
      trigBase   <= '0;
      trigStride <= '0;
      trigSecure <= 1'b0;
    end else begin
      trigValid <= strb.fire;
      if (strb.fire) begin
        trigBase   <= reqAddr;
        trigStride <= obsStride;
        trigSecure <= reqSecure;
      end
    end
  end
endmodule

// File: rtl/stride_ctrl.sv
`timescale 1ns/1ps
module stride_ctrl
  import stride_pkg::*;
#(
  parameter int WAYS       = 4,
  parameter int CONF_W     = 3,
  parameter int WAY_W      = 2,
  parameter int MAX_CONF   = 7,
  parameter int THR_CONF   = 4,
  parameter int MIN_CONF   = 0,
  parameter int START_CONF = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqHasPc,
  input  logic              reqIsFetch,
  input  logic              hit,
  input  logic [WAY_W-1:0]  hitWay,
  input  logic [CONF_W-1:0] curConf,
  input  logic              strideEq,
  output strobe_t           strb,
  output logic [WAY_W-1:0]  wrWay,
  output logic [CONF_W-1:0] confNext
);
  logic [7:0] lfsr;
  logic       accept;

  assign accept = reqValid && reqHasPc && !reqIsFetch;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lfsr <= 8'h01;
    else       lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
  end

  always_comb begin
    strb     = '0;
    wrWay    = hitWay;
    confNext = curConf;
    if (accept) begin
      if (hit) begin
        strb.wrHit = 1'b1;
        if (strideEq) begin
          if (curConf < CONF_W'(MAX_CONF)) confNext = curConf + 1'b1;
        end else begin
          if (curConf > CONF_W'(MIN_CONF)) confNext = curConf - 1'b1;
          strb.retrain = (confNext < CONF_W'(THR_CONF));
        end
        strb.fire = (confNext >= CONF_W'(THR_CONF));
      end else begin
        strb.wrFill = 1'b1;
        wrWay       = lfsr[WAY_W-1:0];
        confNext    = CONF_W'(START_CONF);
      end
    end
  end
endmodule

// File: rtl/stride_trainer.sv
`timescale 1ns/1ps
module stride_trainer
  import stride_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int ADDR_W     = 32,
  parameter int SETS       = 16,
  parameter int WAYS       = 4,
  parameter int CTXS       = 2,
  parameter int MAX_CONF   = 7,
  parameter int THR_CONF   = 4,
  parameter int MIN_CONF   = 0,
  parameter int START_CONF = 4,
  localparam int CTX_W     = (CTXS > 1) ? $clog2(CTXS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [PC_W-1:0]   reqPc,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqSecure,
  input  logic [CTX_W-1:0]  reqCtx,
  input  logic              reqIsFetch,
  input  logic              reqHasPc,
  output logic              trigValid,
  output logic [ADDR_W-1:0] trigBase,
  output logic [ADDR_W-1:0] trigStride,
  output logic              trigSecure
);
  localparam int CONF_W = $clog2(MAX_CONF + 1);
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;

  strobe_t           strb;
  logic [WAY_W-1:0]  wrWay, hitWay;
  logic [CONF_W-1:0] confNext, curConf;
  logic              hit, strideEq;
  logic [WAYS-1:0]   matchVec;

  stride_ctrl #(
    .WAYS(WAYS), .CONF_W(CONF_W), .WAY_W(WAY_W), .MAX_CONF(MAX_CONF),
    .THR_CONF(THR_CONF), .MIN_CONF(MIN_CONF), .START_CONF(START_CONF)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqHasPc(reqHasPc),
    .reqIsFetch(reqIsFetch), .hit(hit), .hitWay(hitWay), .curConf(curConf),
    .strideEq(strideEq), .strb(strb), .wrWay(wrWay), .confNext(confNext)
  );

  stride_dp #(
    .PC_W(PC_W), .ADDR_W(ADDR_W), .SETS(SETS), .WAYS(WAYS), .CTXS(CTXS),
    .CONF_W(CONF_W), .CTX_W(CTX_W), .WAY_W(WAY_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .reqPc(reqPc), .reqAddr(reqAddr),
    .reqSecure(reqSecure), .reqCtx(reqCtx), .strb(strb), .wrWay(wrWay),
    .confNext(confNext), .hit(hit), .hitWay(hitWay), .curConf(curConf),
    .strideEq(strideEq), .matchVec(matchVec), .trigValid(trigValid),
    .trigBase(trigBase), .trigStride(trigStride), .trigSecure(trigSecure)
  );
endmodule

// File: rtl/stride_trainer_chk.sv
`timescale 1ns/1ps
module stride_trainer_chk
  import stride_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int WAYS     = 4,
  parameter int CONF_W   = 3,
  parameter int MAX_CONF = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqHasPc,
  input logic              reqIsFetch,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              reqSecure,
  input logic              trigValid,
  input logic [ADDR_W-1:0] trigBase,
  input logic              trigSecure,
  input logic [WAYS-1:0]   matchVec,
  input strobe_t           strb,
  input logic [CONF_W-1:0] confNext
);
  // dropped requests write nothing and fire nothing
  p_drop_r1: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && (!reqHasPc || reqIsFetch)) |-> (!strb.wrHit && !strb.wrFill && !strb.fire));

  p_drop_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && (!reqHasPc || reqIsFetch)) |=> !trigValid);

  // a PC/secure pair never sits in two ways of one set
  p_unique_hit_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(matchVec));

  p_conf_cap_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrHit || strb.wrFill) |-> (confNext <= CONF_W'(MAX_CONF)));

  p_trig_base_r7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && strb.fire) |=> (trigValid && trigBase == $past(reqAddr)
                                 && trigSecure == $past(reqSecure)));

  p_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !trigValid);

  p_fill_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrFill |-> (!strb.fire && !strb.wrHit));
endmodule

bind stride_trainer stride_trainer_chk #(
  .ADDR_W(ADDR_W), .WAYS(WAYS), .CONF_W(CONF_W), .MAX_CONF(MAX_CONF)
) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqHasPc(reqHasPc),
  .reqIsFetch(reqIsFetch), .reqAddr(reqAddr), .reqSecure(reqSecure),
  .trigValid(trigValid), .trigBase(trigBase), .trigSecure(trigSecure),
  .matchVec(matchVec), .strb(strb), .confNext(confNext)
);

// File: tb/stride_trainer_tb.sv
`timescale 1ns/1ps
module stride_trainer_tb;
  localparam int NSETS = 16, NWAYS = 4, NCTX = 2;
  localparam int CMAX = 7, CTHR = 4, CMIN = 0, CSTART = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqSecure = 1'b0, reqIsFetch = 1'b0, reqHasPc = 1'b0;
  logic [31:0] reqPc = '0, reqAddr = '0;
  logic [0:0]  reqCtx = '0;
  logic        trigValid, trigSecure;
  logic [31:0] trigBase, trigStride;

  int checks = 0, errors = 0;
  bit done = 0;

  // behavioural reference state
  bit          mV  [NCTX][NSETS][NWAYS];
  logic [31:0] mPc [NCTX][NSETS][NWAYS];
  bit          mS  [NCTX][NSETS][NWAYS];
  logic [31:0] mL  [NCTX][NSETS][NWAYS];
  logic [31:0] mSt [NCTX][NSETS][NWAYS];
  int          mC  [NCTX][NSETS][NWAYS];
  int          lf;

  always #2.5 clk = ~clk;

  stride_trainer u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqPc(reqPc),
    .reqAddr(reqAddr), .reqSecure(reqSecure), .reqCtx(reqCtx),
    .reqIsFetch(reqIsFetch), .reqHasPc(reqHasPc), .trigValid(trigValid),
    .trigBase(trigBase), .trigStride(trigStride), .trigSecure(trigSecure)
  );

  function automatic int setOf(logic [31:0] pc);
    logic [31:0] h1;
    h1 = pc >> 1;
    return int'((h1 ^ (h1 >> 4)) & 32'hF);
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(bit v, logic [31:0] pc, logic [31:0] addr, bit sec,
                      bit ctx, bit fetch, bit hasPc, string tag);
    bit expV = 0, expSec = 0, found = 0;
    logic [31:0] expBase = '0, obs = '0;
    int s, hw = 0;
    reqValid = v; reqPc = pc; reqAddr = addr; reqSecure = sec;
    reqCtx = ctx; reqIsFetch = fetch; reqHasPc = hasPc;
    if (v && hasPc && !fetch) begin
      s = setOf(pc);
      for (int w = 0; w < NWAYS; w++)
        if (!found && mV[ctx][s][w] && mPc[ctx][s][w] == pc && mS[ctx][s][w] == sec) begin
          found = 1; hw = w;
        end
      if (found) begin
        obs = addr - mL[ctx][s][hw];
        if (obs == mSt[ctx][s][hw]) begin
          if (mC[ctx][s][hw] < CMAX) mC[ctx][s][hw]++;
        end else begin
          if (mC[ctx][s][hw] > CMIN) mC[ctx][s][hw]--;
          if (mC[ctx][s][hw] < CTHR) mSt[ctx][s][hw] = obs;
        end
        mL[ctx][s][hw] = addr;
        if (mC[ctx][s][hw] >= CTHR) begin
          expV = 1; expBase = addr; expSec = sec;
        end
      end else begin
        hw = lf % NWAYS;
        mV[ctx][s][hw] = 1; mPc[ctx][s][hw] = pc; mS[ctx][s][hw] = sec;
        mL[ctx][s][hw] = addr; mSt[ctx][s][hw] = '0; mC[ctx][s][hw] = CSTART;
      end
    end
    @(posedge clk);
    lf = ((lf << 1) & 8'hFE) | (((lf >> 7) ^ (lf >> 5) ^ (lf >> 4) ^ (lf >> 3)) & 1);
    @(negedge clk);
    chk(tag, "trigValid", {31'd0, trigValid}, {31'd0, expV});
    if (expV) begin
      chk(tag, "trigBase", trigBase, expBase);
      chk(tag, "trigStride", trigStride, obs);
      chk(tag, "trigSecure", {31'd0, trigSecure}, {31'd0, expSec});
    end
  endtask

  task automatic req(logic [31:0] pc, logic [31:0] addr, bit sec, bit ctx, string tag);
    step(1, pc, addr, sec, ctx, 0, 1, tag);
  endtask

  initial begin
    for (int c = 0; c < NCTX; c++)
      for (int s = 0; s < NSETS; s++)
        for (int w = 0; w < NWAYS; w++) mV[c][s][w] = 0;
    lf = 1;
    repeat (3) @(negedge clk);
    chk("R10", "trigValid in reset", {31'd0, trigValid}, 32'd0);
    rstN = 1'b1;
    step(0, 32'h400, 32'h1000, 0, 0, 0, 1, "R10");

    // R1: dropped requests must not allocate
    step(1, 32'h400, 32'h1000, 0, 0, 0, 0, "R1");
    step(1, 32'h400, 32'h1040, 0, 0, 1, 1, "R1");
    req(32'h400, 32'h2000, 0, 0, "R8");
    req(32'h400, 32'h2040, 0, 0, "R5");
    req(32'h400, 32'h2080, 0, 0, "R4");
    for (int i = 3; i < 8; i++) req(32'h400, 32'h2000 + 32'(i) * 32'h40, 0, 0, "R4");
    // mismatch from saturation: trigger carries observed stride
    req(32'h400, 32'h21d0, 0, 0, "R7");
    req(32'h400, 32'h21e0, 0, 0, "R5");
    req(32'h400, 32'h21f0, 0, 0, "R5");
    req(32'h400, 32'h2200, 0, 0, "R5");
    req(32'h400, 32'h2210, 0, 0, "R6");
    // drive confidence to the floor and hold
    for (int i = 0; i < 9; i++) req(32'h400, 32'h3000 + 32'(i * i) * 32'h8, 0, 0, "R5");
    step(0, 32'h400, 32'h9000, 0, 0, 0, 1, "R7");

    // R3: secure flag and context separate entries
    req(32'h400, 32'h5000, 1, 0, "R3");
    req(32'h400, 32'h5040, 1, 0, "R3");
    req(32'h400, 32'h5080, 1, 0, "R3");
    req(32'h400, 32'h6000, 0, 1, "R3");
    req(32'h400, 32'h6100, 0, 1, "R3");
    req(32'h400, 32'h6200, 0, 1, "R3");
    // negative stride
    for (int i = 0; i < 5; i++) req(32'h8, 32'h8000 - 32'(i) * 32'h10, 0, 0, "R4");

    // R2 / R8 / R9: many PCs folding into set 0 force random eviction
    for (int r = 0; r < 4; r++)
      for (int k = 1; k <= 7; k++)
        req(32'(k) * 32'h400, 32'h10000 * 32'(k) + 32'(r) * 32'h80, 0, 0, "R8");
    for (int k = 0; k < 24; k++) begin
      req(32'(k) * 32'h2, 32'h40000 + 32'(k) * 32'h100, k[0], 0, "R2");
      req(32'(k) * 32'h2, 32'h40040 + 32'(k) * 32'h100, k[0], 0, "R2");
      req(32'(k) * 32'h2, 32'h40080 + 32'(k) * 32'h100, k[0], 0, "R9");
      if (k % 3 == 0) step(0, 32'h0, 32'h0, 0, 0, 0, 0, "R9");
    end
    for (int k = 0; k < 24; k++)
      req(32'(k) * 32'h2, 32'h400c0 + 32'(k) * 32'h100, k[0], 0, "R6");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule